// File: doc/BRIEF.md
# System Control Register Bank

This block is a byte-wide set of board control registers sitting on a legacy 16-bit I/O bus. It answers at one stand-alone port that carries a software-driven reset request, and in a small window of byte addresses that holds identification registers with fixed contents. The window also holds the board controls: a disk activity light, two lock strobes toward a non-volatile memory, a 4-bit system control register and a bit that chooses how the host I/O window is translated.

Writes take effect on the rising clock edge on which `io_wr` is high. Reads are combinational: while `io_rd` is high, `io_rdata` reflects the addressed register in the same cycle, and it reads 0x00 while `io_rd` is low. Addresses the bank does not decode read as all ones, and writes to them are dropped. The reset request and the light are levels that hold until they are written again. The lock strobes are single-cycle pulses.

Top module: `sysctl_bank`

## Requirements
- R1: After the asynchronous reset, `reset_req`, `disk_light`, `map_noncontig`, `nv_lock1` and `nv_lock2` are all 0, and the system control and map registers read 0x00.
- R2: A write to port 0x0092 sets `reset_req` to bit 0 of the written byte from the next cycle on, and the level holds until the next write to that port; a read of 0x0092 returns `reset_req` in bit 0 with bits 7..1 zero.
- R3: Reads of 0x0800, 0x0801, 0x0802, 0x0803 and 0x081D return 0xEF, 0xAD, 0xE0, 0x39 and 0x03, and writes to those addresses leave both the read value and all outputs unchanged.
- R4: A write to 0x081C stores bits 3..0 of the byte, and a read of 0x081C returns that value with bits 7..4 zero.
- R5: A write to 0x0850 stores bit 0 of the byte and drives it on `map_noncontig`, and a read of 0x0850 returns it in bit 0 with bits 7..1 zero.
- R6: A write to 0x0808 sets `disk_light` to bit 0 of the byte, and the level holds until the next write there.
- R7: A write of any value to 0x0810 makes `nv_lock1` high for exactly the one cycle after the write edge, and a write to 0x0811 does the same on `nv_lock2`; the other strobe stays low.
- R8: A read of any address outside 0x0092 and the decoded window registers, including 0x07FF and 0x0852 just outside the window, returns 0xFF, and a write to such an address changes no output or readable state.
- R9: A write to the cache invalidate location 0x0814 has no effect on any output or readable state, and it reads 0xFF.
- R10: While `io_rd` is low, `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe, enables the read data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the address |
| reset_req | output | 1 | Held soft reset request to the processor |
| disk_light | output | 1 | Disk activity light |
| nv_lock1 | output | 1 | One-cycle toggle strobe for NVRAM lock 1 |
| nv_lock2 | output | 1 | One-cycle toggle strobe for NVRAM lock 2 |
| map_noncontig | output | 1 | I/O map type: 1 selects the non-contiguous translation |

## Verification
Random reads and writes over a pool of every decoded address plus the first and last addresses past the window edges separate a decode that is off by one from a correct one. Fully random 16-bit addresses show that nothing outside the bank disturbs its state. Random data with the high nibble and the upper seven bits set tells a masked store apart from a full-byte store. Back-to-back writes to the two lock addresses, and writes to the fixed registers and the cache invalidate location followed by a read, show that the strobes stay single-cycle and that the ignored writes leave no trace.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Register selects produced by the address decoder (at most one is high)
  typedef struct packed {
    logic rst;
    logic cpucfg;
    logic feat;
    logic mstat;
    logic xfeat;
    logic l2stat;
    logic light;
    logic lock1;
    logic lock2;
    logic sysctl;
    logic maptype;
  } sysctl_sel_t;

  localparam int unsigned NUM_LOCKS = 2;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RST_PORT   = 16'h0092,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 16'h0800,
  parameter logic [ADDR_W-1:0] WIN_SIZE   = 16'h0052,
  parameter logic [ADDR_W-1:0] OFS_CPUCFG = 16'h0000,
  parameter logic [ADDR_W-1:0] OFS_FEAT   = 16'h0001,
  parameter logic [ADDR_W-1:0] OFS_MSTAT  = 16'h0002,
  parameter logic [ADDR_W-1:0] OFS_XFEAT  = 16'h0003,
  parameter logic [ADDR_W-1:0] OFS_LIGHT  = 16'h0008,
  parameter logic [ADDR_W-1:0] OFS_LOCK1  = 16'h0010,
  parameter logic [ADDR_W-1:0] OFS_LOCK2  = 16'h0011,
  parameter logic [ADDR_W-1:0] OFS_SYSCTL = 16'h001C,
  parameter logic [ADDR_W-1:0] OFS_L2STAT = 16'h001D,
  parameter logic [ADDR_W-1:0] OFS_MAP    = 16'h0050
) (
  input  logic [ADDR_W-1:0] addr,
  output sysctl_sel_t       sel
);

  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + WIN_SIZE;

  logic              in_win;
  logic [ADDR_W-1:0] off;

  always_comb begin
    in_win     = (addr >= WIN_BASE) && (addr < WIN_END);
    off        = addr - WIN_BASE;
    sel.rst    = (addr == RST_PORT);
    sel.cpucfg = in_win && (off == OFS_CPUCFG);
    sel.feat   = in_win && (off == OFS_FEAT);
    sel.mstat  = in_win && (off == OFS_MSTAT);
    sel.xfeat  = in_win && (off == OFS_XFEAT);
    sel.l2stat = in_win && (off == OFS_L2STAT);
    sel.light  = in_win && (off == OFS_LIGHT);
    sel.lock1  = in_win && (off == OFS_LOCK1);
    sel.lock2  = in_win && (off == OFS_LOCK2);
    sel.sysctl = in_win && (off == OFS_SYSCTL);
    sel.maptype = in_win && (off == OFS_MAP);
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYSCTL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr_rst,
  input  logic                 wr_light,
  input  logic                 wr_sysctl,
  input  logic                 wr_map,
  input  logic [NUM_LOCKS-1:0] wr_lock,
  output logic                 rst_q,
  output logic                 light_q,
  output logic [DATA_W-1:0]    sysctl_q,
  output logic                 map_q,
  output logic [NUM_LOCKS-1:0] lock_q
);

  localparam logic [DATA_W-1:0] SYSCTL_MASK = DATA_W'((1 << SYSCTL_W) - 1);

  logic              rst_d, light_d, map_d;
  logic [DATA_W-1:0] sysctl_d;

  // Next-state logic: each register loads only under its own enable
  always_comb begin
    rst_d    = wr_rst    ? wdata[0] : rst_q;
    light_d  = wr_light  ? wdata[0] : light_q;
    map_d    = wr_map    ? wdata[0] : map_q;
    sysctl_d = wr_sysctl ? (wdata & SYSCTL_MASK) : sysctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q    <= 1'b0;
      light_q  <= 1'b0;
      map_q    <= 1'b0;
      sysctl_q <= '0;
    end else begin
      rst_q    <= rst_d;
      light_q  <= light_d;
      map_q    <= map_d;
      sysctl_q <= sysctl_d;
    end
  end

  // Lock strobes: one flop per lock, high for the cycle after the write
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[i] <= 1'b0;
      else        lock_q[i] <= wr_lock[i];
    end

    AST_LOCK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |-> $past(wr_lock[i])); // R7
  end

  AST_RST_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (rst_q == $past(wdata[0]))); // R2
  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rst |=> $stable(rst_q)); // R2
  AST_LIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_light |=> $stable(light_q)); // R6
  AST_LOCKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_q[0] && lock_q[1])); // R7

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] VAL_CPUCFG = 8'hEF,
  parameter logic [DATA_W-1:0] VAL_FEAT   = 8'hAD,
  parameter logic [DATA_W-1:0] VAL_MSTAT  = 8'hE0,
  parameter logic [DATA_W-1:0] VAL_XFEAT  = 8'h39,
  parameter logic [DATA_W-1:0] VAL_L2STAT = 8'h03
) (
  input  logic              rd_en,
  input  logic              sel_rst,
  input  logic              sel_cpucfg,
  input  logic              sel_feat,
  input  logic              sel_mstat,
  input  logic              sel_xfeat,
  input  logic              sel_l2stat,
  input  logic              sel_sysctl,
  input  logic              sel_map,
  input  logic              rst_q,
  input  logic [DATA_W-1:0] sysctl_q,
  input  logic              map_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] UNMAPPED = '1;

  always_comb begin
    if (!rd_en)          rdata = '0;
    else if (sel_rst)    rdata = {{(DATA_W-1){1'b0}}, rst_q};
    else if (sel_cpucfg) rdata = VAL_CPUCFG;
    else if (sel_feat)   rdata = VAL_FEAT;
    else if (sel_mstat)  rdata = VAL_MSTAT;
    else if (sel_xfeat)  rdata = VAL_XFEAT;
    else if (sel_l2stat) rdata = VAL_L2STAT;
    else if (sel_sysctl) rdata = sysctl_q;
    else if (sel_map)    rdata = {{(DATA_W-1){1'b0}}, map_q};
    else                 rdata = UNMAPPED;
  end

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYSCTL_W = 4,
  parameter logic [ADDR_W-1:0] RST_PORT   = 16'h0092,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 16'h0800,
  parameter logic [ADDR_W-1:0] WIN_SIZE   = 16'h0052,
  parameter logic [ADDR_W-1:0] OFS_CPUCFG = 16'h0000,
  parameter logic [ADDR_W-1:0] OFS_FEAT   = 16'h0001,
  parameter logic [ADDR_W-1:0] OFS_MSTAT  = 16'h0002,
  parameter logic [ADDR_W-1:0] OFS_XFEAT  = 16'h0003,
  parameter logic [ADDR_W-1:0] OFS_LIGHT  = 16'h0008,
  parameter logic [ADDR_W-1:0] OFS_LOCK1  = 16'h0010,
  parameter logic [ADDR_W-1:0] OFS_LOCK2  = 16'h0011,
  parameter logic [ADDR_W-1:0] OFS_SYSCTL = 16'h001C,
  parameter logic [ADDR_W-1:0] OFS_L2STAT = 16'h001D,
  parameter logic [ADDR_W-1:0] OFS_MAP    = 16'h0050,
  parameter logic [DATA_W-1:0] VAL_CPUCFG = 8'hEF,
  parameter logic [DATA_W-1:0] VAL_FEAT   = 8'hAD,
  parameter logic [DATA_W-1:0] VAL_MSTAT  = 8'hE0,
  parameter logic [DATA_W-1:0] VAL_XFEAT  = 8'h39,
  parameter logic [DATA_W-1:0] VAL_L2STAT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              reset_req,
  output logic              disk_light,
  output logic              nv_lock1,
  output logic              nv_lock2,
  output logic              map_noncontig
);

  sysctl_sel_t           sel;
  logic [NUM_LOCKS-1:0]  wr_lock;
  logic [NUM_LOCKS-1:0]  lock_q;
  logic [DATA_W-1:0]     sysctl_q;
  logic                  rst_q, light_q, map_q;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .RST_PORT(RST_PORT), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
    .OFS_CPUCFG(OFS_CPUCFG), .OFS_FEAT(OFS_FEAT), .OFS_MSTAT(OFS_MSTAT),
    .OFS_XFEAT(OFS_XFEAT), .OFS_LIGHT(OFS_LIGHT), .OFS_LOCK1(OFS_LOCK1),
    .OFS_LOCK2(OFS_LOCK2), .OFS_SYSCTL(OFS_SYSCTL), .OFS_L2STAT(OFS_L2STAT),
    .OFS_MAP(OFS_MAP)
  ) u_decode (
    .addr (io_addr),
    .sel  (sel)
  );

  assign wr_lock = {io_wr && sel.lock2, io_wr && sel.lock1};

  sysctl_regs #(.DATA_W(DATA_W), .SYSCTL_W(SYSCTL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (io_wdata),
    .wr_rst    (io_wr && sel.rst),
    .wr_light  (io_wr && sel.light),
    .wr_sysctl (io_wr && sel.sysctl),
    .wr_map    (io_wr && sel.maptype),
    .wr_lock   (wr_lock),
    .rst_q     (rst_q),
    .light_q   (light_q),
    .sysctl_q  (sysctl_q),
    .map_q     (map_q),
    .lock_q    (lock_q)
  );

  sysctl_rdmux #(
    .DATA_W(DATA_W), .VAL_CPUCFG(VAL_CPUCFG), .VAL_FEAT(VAL_FEAT),
    .VAL_MSTAT(VAL_MSTAT), .VAL_XFEAT(VAL_XFEAT), .VAL_L2STAT(VAL_L2STAT)
  ) u_rdmux (
    .rd_en      (io_rd),
    .sel_rst    (sel.rst),
    .sel_cpucfg (sel.cpucfg),
    .sel_feat   (sel.feat),
    .sel_mstat  (sel.mstat),
    .sel_xfeat  (sel.xfeat),
    .sel_l2stat (sel.l2stat),
    .sel_sysctl (sel.sysctl),
    .sel_map    (sel.maptype),
    .rst_q      (rst_q),
    .sysctl_q   (sysctl_q),
    .map_q      (map_q),
    .rdata      (io_rdata)
  );

  assign reset_req     = rst_q;
  assign disk_light    = light_q;
  assign map_noncontig = map_q;
  assign nv_lock1      = lock_q[0];
  assign nv_lock2      = lock_q[1];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R8
  AST_SYSCTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && sel.sysctl) |-> (io_rdata[DATA_W-1:SYSCTL_W] == '0)); // R4
  AST_MAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && sel.maptype) |=> $stable(map_noncontig)); // R5
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0)); // R10

endmodule

// File: tb/sysctl_bank_tb.sv
`timescale 1ns/1ps
module sysctl_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic        reset_req, disk_light, nv_lock1, nv_lock2, map_noncontig;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model of the writable state
  logic       m_rst, m_light, m_map, e_l1, e_l2;
  logic [3:0] m_sys;

  always #2 clk = ~clk;

  sysctl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .reset_req(reset_req),
    .disk_light(disk_light), .nv_lock1(nv_lock1), .nv_lock2(nv_lock2),
    .map_noncontig(map_noncontig)
  );

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    case (a)
      16'h0092: return {7'b0, m_rst};
      16'h0800: return 8'hEF;
      16'h0801: return 8'hAD;
      16'h0802: return 8'hE0;
      16'h0803: return 8'h39;
      16'h081D: return 8'h03;
      16'h081C: return {4'b0, m_sys};
      16'h0850: return {7'b0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    check(reset_req == m_rst, {req, " R2 reset_req"}, {7'b0, reset_req}, {7'b0, m_rst});
    check(disk_light == m_light, {req, " R6 disk_light"}, {7'b0, disk_light}, {7'b0, m_light});
    check(map_noncontig == m_map, {req, " R5 map_noncontig"}, {7'b0, map_noncontig}, {7'b0, m_map});
    check(nv_lock1 == e_l1, {req, " R7 nv_lock1"}, {7'b0, nv_lock1}, {7'b0, e_l1});
    check(nv_lock2 == e_l2, {req, " R7 nv_lock2"}, {7'b0, nv_lock2}, {7'b0, e_l2});
  endtask

  // Write: drive at negedge, edge applies it, check pulse cycle, then idle cycle
  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
    case (a)
      16'h0092: m_rst   = d[0];
      16'h0808: m_light = d[0];
      16'h081C: m_sys   = d[3:0];
      16'h0850: m_map   = d[0];
      default: ;
    endcase
    e_l1 = (a == 16'h0810);
    e_l2 = (a == 16'h0811);
    check_outs(req);
    @(negedge clk);
    e_l1 = 1'b0; e_l2 = 1'b0;
    check_outs({req, " after"});
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
    #1;
    e = exp_read(a);
    check(io_rdata == e, req, io_rdata, e);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  logic [15:0] pool [0:15];

  initial begin
    pool[0] = 16'h0092; pool[1] = 16'h0800; pool[2] = 16'h0801; pool[3] = 16'h0802;
    pool[4] = 16'h0803; pool[5] = 16'h081D; pool[6] = 16'h081C; pool[7] = 16'h0850;
    pool[8] = 16'h0808; pool[9] = 16'h0810; pool[10] = 16'h0811; pool[11] = 16'h0814;
    pool[12] = 16'h07FF; pool[13] = 16'h0852; pool[14] = 16'h0851; pool[15] = 16'h0093;
    m_rst = 0; m_light = 0; m_map = 0; m_sys = 0; e_l1 = 0; e_l2 = 0;
    io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check_outs("R1 reset");
    do_read(16'h081C, "R1 sysctl after reset");
    do_read(16'h0850, "R1 map after reset");

    // R10: idle read data
    @(negedge clk);
    io_addr = 16'h0800; io_rd = 1'b0; #1;
    check(io_rdata == 8'h00, "R10 idle rdata", io_rdata, 8'h00);

    // R2: soft reset level
    do_write(16'h0092, 8'hFF, "R2 set");
    do_read(16'h0092, "R2 readback set");
    do_write(16'h0092, 8'hFE, "R2 clear");
    do_read(16'h0092, "R2 readback clear");

    // R3: fixed values, write ignored
    do_write(16'h0800, 8'h00, "R3 write fixed");
    do_read(16'h0800, "R3 cpu config");
    do_read(16'h0801, "R3 feature");
    do_read(16'h0802, "R3 status");
    do_read(16'h0803, "R3 ext feature");
    do_read(16'h081D, "R3 cache status");

    // R4: masked store
    do_write(16'h081C, 8'hF5, "R4 write");
    do_read(16'h081C, "R4 masked read");

    // R5: map bit
    do_write(16'h0850, 8'hFF, "R5 write");
    do_read(16'h0850, "R5 read");

    // R6: light
    do_write(16'h0808, 8'h01, "R6 on");
    do_write(16'h0808, 8'hFE, "R6 off");

    // R7: back-to-back lock strobes
    @(negedge clk);
    io_addr = 16'h0810; io_wdata = 8'h00; io_wr = 1'b1;
    @(negedge clk);
    io_addr = 16'h0811;
    check(nv_lock1 && !nv_lock2, "R7 lock1 pulse", {6'b0, nv_lock2, nv_lock1}, 8'h01);
    @(negedge clk);
    io_wr = 1'b0;
    check(!nv_lock1 && nv_lock2, "R7 lock2 pulse", {6'b0, nv_lock2, nv_lock1}, 8'h02);
    @(negedge clk);
    check(!nv_lock1 && !nv_lock2, "R7 strobes end", {6'b0, nv_lock2, nv_lock1}, 8'h00);

    // R8 / R9: edges, unassigned and cache invalidate
    do_write(16'h0814, 8'hFF, "R9 invalidate write");
    do_read(16'h0814, "R9 invalidate read");
    do_write(16'h07FF, 8'hFF, "R8 below window write");
    do_write(16'h0852, 8'hFF, "R8 above window write");
    do_read(16'h07FF, "R8 below window read");
    do_read(16'h0852, "R8 above window read");
    do_read(16'h0851, "R8 unassigned in window");
    do_read(16'h081C, "R8 sysctl untouched");
    do_read(16'h0850, "R8 map untouched");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = ($urandom % 4 == 0) ? 16'($urandom) : pool[$urandom % 16];
      d = 8'($urandom);
      if ($urandom % 2 == 0) do_write(a, d, "R8 random write");
      else                   do_read(a, "R8 random read");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule